// File: doc/BRIEF.md
# Full-Speed Line Receiver: NRZI Decode and Bit Unstuffing

The block sits behind a full-speed serial bus front end that has already brought the two differential data lines into the local clock domain. The lines are oversampled at a fixed ratio `OSR` of the 12 Mb/s bit rate. Each clock, the line pair is read as one of four symbols. A packet begins on the first K after idle. From that point the block picks one sample per bit near the middle of the bit cell. It turns the changes between samples into data bits, removes the zeros that the transmitter inserted after long runs of ones, and stops at the end-of-packet marker.

Downstream logic receives single-cycle pulses. There is a start pulse, a data strobe with its bit value, a strobe for each bit that was removed, an error pulse when a run of ones breaks the stuffing rule, and an end pulse. The sample grid is realigned on every J/K transition, so a slow drift between the two ends of the link does not build up over a packet.

Top module: `fsrx_nrzi`

## Requirements
- R1: Symbols are classified from `dp`/`dm` as J (1,0), K (0,1), SE0 (0,0) and SE1 (1,1), with the internal codes J=0, K=1, SE0=2 and SE1=3. After reset all outputs are 0 and the block is idle. Its remembered symbol is J.
- R2: While idle, any symbol other than K is only remembered and produces no output. The first K starts a packet. `sop` pulses for one clock, in the cycle after the edge that captured that K.
- R3: The first bit sample is taken `OSR/2` clocks after the edge that captured the start K. Later samples follow every `OSR` clocks. A result appears on the outputs in the cycle after its sample edge.
- R4: During a packet, a change between J and K on the line restarts the grid, so that the next sample is taken `OSR/2` clocks after the edge that captured the change.
- R5: For a sampled J or K, the decoded bit is 1 when the symbol equals the previously sampled symbol and 0 when it differs. The previous symbol at the start of a packet is the symbol remembered in idle. `bit_vld` pulses for one clock and `bit_val` carries the bit.
- R6: A decoded 1 adds to a count of consecutive ones. A decoded 0 clears the count, and so does the start of a packet. When the count is 6, a decoded 0 is dropped: `stuff_vld` pulses instead of `bit_vld`, and the count clears.
- R7: When the count is 6, a decoded 1 raises `stuff_err` for one clock and returns the block to idle. No data or stuff strobe follows until a new K starts a packet.
- R8: A sampled J that directly follows a sampled SE0 raises `eop` for one clock, produces no data bit, and returns the block to idle.
- R9: A sampled SE0 or SE1 produces no data bit and leaves the ones count unchanged. It does become the previous symbol for the next decode.
- R10: In any clock, at most one of `sop`, `bit_vld`, `stuff_vld`, `stuff_err` and `eop` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `OSR` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp | input | 1 | Synchronised positive data line |
| dm | input | 1 | Synchronised negative data line |
| sop | output | 1 | Start-of-packet pulse |
| bit_vld | output | 1 | Decoded data bit strobe |
| bit_val | output | 1 | Decoded data bit value, valid with `bit_vld` |
| stuff_vld | output | 1 | Pulse for a removed stuff bit |
| stuff_err | output | 1 | Pulse for a stuffing violation; packet aborted |
| eop | output | 1 | End-of-packet pulse |

## Verification
The bench checks runs of ones that end exactly at six, both with the stuffed zero present and with a seventh one. A design that counted off by one would drop a real data zero or let the violation through as data. It stretches and shortens single bit cells to test realignment. A decoder without realignment, or one that restarts the grid one clock late, shows its data strobes a cycle away from the expected cycle. It also places SE1 inside a packet and SE1/SE0 on an idle line, which would expose a design that decodes a data bit from a single-ended symbol or that starts a packet on anything but K. Finally, it ends packets with both one and two SE0 bit times, and checks that the closing J yields no data bit.

// File: rtl/fsrx_nrzi.sv
module fsrx_nrzi #(
  parameter int OSR     = 4,
  parameter int RUN_MAX = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp,
  input  logic dm,
  output logic sop,
  output logic bit_vld,
  output logic bit_val,
  output logic stuff_vld,
  output logic stuff_err,
  output logic eop
);
  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int OW = $clog2(RUN_MAX + 1);
  localparam logic [CW-1:0] HALF_LD = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL_LD = CW'(OSR - 1);
  localparam logic [1:0] SYM_J   = 2'd0;
  localparam logic [1:0] SYM_K   = 2'd1;
  localparam logic [1:0] SYM_SE0 = 2'd2;
  localparam logic [1:0] SYM_SE1 = 2'd3;

  logic [1:0]    sym, prev_smp, last_raw;
  logic          busy;
  logic [CW-1:0] cnt;
  logic [OW-1:0] ones;

  assign sym = ( dp && !dm) ? SYM_J :
               (!dp &&  dm) ? SYM_K :
               ( dp &&  dm) ? SYM_SE1 : SYM_SE0;

  wire is_jk    = !sym[1];
  wire edge_jk  = busy && is_jk && !last_raw[1] && (sym != last_raw);
  wire smp      = busy && (cnt == '0);
  wire smp_eop  = smp && (prev_smp == SYM_SE0) && (sym == SYM_J);
  wire smp_bit  = smp && is_jk && !smp_eop;
  wire nrzi_one = (sym == prev_smp);
  wire at_run   = (ones == OW'(RUN_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      ones      <= '0;
      prev_smp  <= SYM_J;
      last_raw  <= SYM_J;
      sop       <= 1'b0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      stuff_vld <= 1'b0;
      stuff_err <= 1'b0;
      eop       <= 1'b0;
    end else begin
      sop       <= 1'b0;
      bit_vld   <= 1'b0;
      stuff_vld <= 1'b0;
      stuff_err <= 1'b0;
      eop       <= 1'b0;
      last_raw  <= sym;
      if (!busy) begin
        if (sym == SYM_K) begin
          busy <= 1'b1;
          sop  <= 1'b1;
          ones <= '0;
          cnt  <= HALF_LD;
        end else begin
          prev_smp <= sym;
        end
      end else begin
        if (edge_jk)          cnt <= HALF_LD;
        else if (cnt == '0)   cnt <= FULL_LD;
        else                  cnt <= cnt - 1'b1;
        if (smp) begin
          prev_smp <= sym;
          if (smp_eop) begin
            eop  <= 1'b1;
            busy <= 1'b0;
          end else if (smp_bit) begin
            if (at_run) begin
              if (nrzi_one) begin
                stuff_err <= 1'b1;
                busy      <= 1'b0;
              end else begin
                stuff_vld <= 1'b1;
                ones      <= '0;
              end
            end else begin
              bit_vld <= 1'b1;
              bit_val <= nrzi_one;
              ones    <= nrzi_one ? ones + 1'b1 : '0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/fsrx_nrzi_chk.sv
module fsrx_nrzi_chk #(
  parameter int RUN_MAX = 6
) (
  input logic clk,
  input logic rst_n,
  input logic dp,
  input logic dm,
  input logic sop,
  input logic bit_vld,
  input logic bit_val,
  input logic stuff_vld,
  input logic stuff_err,
  input logic eop
);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run <= 0;
    else if (sop || stuff_vld) run <= 0;
    else if (bit_vld)          run <= bit_val ? run + 1 : 0;
  end

  // R10
  one_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sop, bit_vld, stuff_vld, stuff_err, eop}));

  // R2
  sop_from_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop |-> (!$past(dp) && $past(dm)));

  // R6
  stuff_at_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_vld |-> (run == RUN_MAX));

  // R6
  bit_below_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> (run < RUN_MAX));

  // R7
  err_at_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> (run == RUN_MAX));

  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |=> (!bit_vld && !stuff_vld && !eop));

  // R3
  bit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld);
endmodule

bind fsrx_nrzi fsrx_nrzi_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .sop(sop),
  .bit_vld(bit_vld), .bit_val(bit_val), .stuff_vld(stuff_vld),
  .stuff_err(stuff_err), .eop(eop)
);

// File: tb/sim_fsrx_nrzi.sv
module sim_fsrx_nrzi;
  localparam int OSR = 4;
  localparam int RUN = 6;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b1, dm = 1'b0;
  logic sop, bit_vld, bit_val, stuff_vld, stuff_err, eop;
  int   cyc = 0, checks = 0, errors = 0;
  bit   chk_on = 1'b0;

  logic [5:0] exp_ev [int];
  int seg_sym[$];
  int seg_len[$];

  fsrx_nrzi #(.OSR(OSR), .RUN_MAX(RUN)) u0 (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .sop(sop),
    .bit_vld(bit_vld), .bit_val(bit_val), .stuff_vld(stuff_vld),
    .stuff_err(stuff_err), .eop(eop)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic set_line(input int s);
    case (s)
      0: begin dp = 1'b1; dm = 1'b0; end
      1: begin dp = 1'b0; dm = 1'b1; end
      2: begin dp = 1'b0; dm = 1'b0; end
      default: begin dp = 1'b1; dm = 1'b1; end
    endcase
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at edge %0d: actual %0d expected %0d", req, what, cyc, act, expv);
    end
  endtask

  // per-cycle comparison against the reference event map
  always @(negedge clk) begin
    if (chk_on) begin
      logic [5:0] e;
      e = exp_ev.exists(cyc) ? exp_ev[cyc] : 6'b0;
      chk(sop == e[5], "R2", "sop", sop, e[5]);
      chk(bit_vld == e[4], "R3 R4 R5", "bit_vld", bit_vld, e[4]);
      if (e[4]) chk(bit_val == e[3], "R5", "bit_val", bit_val, e[3]);
      chk(stuff_vld == e[2], "R6", "stuff_vld", stuff_vld, e[2]);
      chk(stuff_err == e[1], "R7", "stuff_err", stuff_err, e[1]);
      chk(eop == e[0], "R8", "eop", eop, e[0]);
    end
  end

  task automatic add_ev(input int edge_no, input logic [5:0] m);
    if (exp_ev.exists(edge_no)) exp_ev[edge_no] = exp_ev[edge_no] | m;
    else exp_ev[edge_no] = m;
  endtask

  // behavioural decoder reference over the segment list, first segment is the start K
  task automatic build_model(input int p0);
    int t = p0, ns = p0 + OSR / 2, prv = 0, ones = 0;
    bit live = 1'b1;
    add_ev(p0, 6'b100000);
    foreach (seg_sym[i]) begin
      int s = seg_sym[i];
      if (!live) break;
      // R4 realignment on a J/K change
      if (i > 0 && s < 2 && seg_sym[i-1] < 2 && s != seg_sym[i-1]) ns = t + OSR / 2;
      while (live && ns < t + seg_len[i]) begin
        if (prv == 2 && s == 0) begin
          add_ev(ns, 6'b000001);
          live = 1'b0;
        end else if (s < 2) begin
          bit b = (s == prv);
          if (ones == RUN) begin
            if (b) begin add_ev(ns, 6'b000010); live = 1'b0; end
            else begin add_ev(ns, 6'b000100); ones = 0; end
          end else begin
            add_ev(ns, b ? 6'b011000 : 6'b010000);
            ones = b ? ones + 1 : 0;
          end
        end
        prv = s;
        ns += OSR;
      end
      t += seg_len[i];
    end
  endtask

  task automatic run_segments();
    bit first = 1'b1;
    foreach (seg_sym[i]) begin
      for (int c = 0; c < seg_len[i]; c++) begin
        @(negedge clk);
        if (first) begin
          build_model(cyc + 1);
          first = 1'b0;
        end
        set_line(seg_sym[i]);
      end
    end
    seg_sym.delete();
    seg_len.delete();
  endtask

  task automatic idle(input int s, input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      set_line(s);
    end
  endtask

  task automatic encode(input bit bits[$], input bit do_stuff, input int eop_bits);
    int lvl = 0, ones = 0;
    foreach (bits[i]) begin
      if (!bits[i]) lvl = 1 - lvl;
      seg_sym.push_back(lvl); seg_len.push_back(OSR);
      ones = bits[i] ? ones + 1 : 0;
      if (do_stuff && ones == RUN) begin
        lvl = 1 - lvl;
        seg_sym.push_back(lvl); seg_len.push_back(OSR);
        ones = 0;
      end
    end
    seg_sym.push_back(2); seg_len.push_back(OSR * eop_bits);
    seg_sym.push_back(0); seg_len.push_back(OSR);
  endtask

  function automatic void push_byte(ref bit q[$], input logic [7:0] v);
    for (int k = 0; k < 8; k++) q.push_back(v[k]);
  endfunction

  initial begin : watchdog
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog expired at edge %0d: actual 0 expected 1 (run completion)", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit q[$];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sop, bit_vld, stuff_vld, stuff_err, eop} == 5'b0, "R1", "outputs in reset",
        {sop, bit_vld, stuff_vld, stuff_err, eop}, 0);
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R1 R2: idle line with J, SE1 and SE0 yields nothing
    idle(0, 20); idle(3, 8); idle(2, 6); idle(0, 12);

    // R3 R5: plain packet, sync then one byte
    q.delete(); push_byte(q, 8'h80); push_byte(q, 8'hA5);
    encode(q, 1'b1, 2); run_segments(); idle(0, 16);

    // R6: long runs of ones, stuffed zeros removed
    q.delete(); push_byte(q, 8'h80); push_byte(q, 8'hFF); push_byte(q, 8'h3F); push_byte(q, 8'hFF);
    encode(q, 1'b1, 2); run_segments(); idle(0, 16);

    // R4: stretched and shortened bit cells
    q.delete(); push_byte(q, 8'h80); push_byte(q, 8'h5A);
    encode(q, 1'b1, 2);
    seg_len[3] = OSR + 1; seg_len[5] = OSR - 1; seg_len[9] = OSR + 1;
    run_segments(); idle(0, 16);

    // R9: SE1 inside a packet gives no bit, keeps the ones count
    q.delete(); push_byte(q, 8'h80); push_byte(q, 8'hF7);
    encode(q, 1'b1, 2);
    seg_sym.insert(10, 3); seg_len.insert(10, OSR);
    run_segments(); idle(0, 16);

    // R7: seven ones on J level after sync and a zero
    q.delete(); push_byte(q, 8'h80); q.push_back(1'b0);
    for (int k = 0; k < 7; k++) q.push_back(1'b1);
    encode(q, 1'b0, 2); run_segments(); idle(0, 16);

    // R8: single SE0 bit time before J still ends the packet
    q.delete(); push_byte(q, 8'h80); push_byte(q, 8'hC3);
    encode(q, 1'b1, 1); run_segments(); idle(0, 16);

    // recovery after the abort
    q.delete(); push_byte(q, 8'h80); push_byte(q, 8'h7E);
    encode(q, 1'b1, 2); run_segments(); idle(0, 20);

    chk_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule